// File: doc/BRIEF.md
# Raster-Stream 2x2 Neighbourhood Extractor

This block accepts an image as a serial pixel stream, one pixel on each cycle that the input qualifier is high, in scan order: rows from top to bottom, and pixels within a row from left to right. It keeps a history of the most recent pixels it has accepted. From that history it presents a 2x2 neighbourhood on every output cycle. The neighbourhood holds the newest pixel, the pixel to its left, the pixel directly above it and the pixel diagonally up and to the left.

The history is a chain of registers, one image row plus one pixel deep. For an image `IMG_W` pixels wide, the pixel above lies `IMG_W` accepted samples back. The diagonal pixel lies one sample further back. The chain advances only on accepted pixels, so idle cycles in the stream do not disturb the neighbourhood. A position tracker follows the row and column of each pixel. The tracker wraps at the end of the frame, and a start-of-frame marker also restarts it. The output qualifier is raised only when all four window positions lie inside the same frame and none of them wraps across an edge. All outputs are registered and appear one cycle after the pixel that completes the window.

Top module: `win2x2_raster`

## Requirements
- R1: While reset is held and after it is released, `win_vld` is 0 and all four window outputs are 0 until the first accepted pixel.
- R2: When `pix_vld` is 1 on a cycle, `win_cur` on the next cycle equals the pixel presented on that cycle.
- R3: On a cycle where `win_vld` is 1, `win_left` equals the pixel accepted just before the one in `win_cur`.
- R4: On a cycle where `win_vld` is 1, `win_up` equals the pixel accepted `IMG_W` accepted pixels before the one in `win_cur`.
- R5: On a cycle where `win_vld` is 1, `win_upleft` equals the pixel accepted `IMG_W`+1 accepted pixels before the one in `win_cur`.
- R6: A pixel in row 0 of a frame never produces `win_vld` = 1.
- R7: A pixel in column 0 of any row never produces `win_vld` = 1. The window for any other pixel in rows 1 and above is valid.
- R8: After a cycle with `pix_vld` = 0, `win_vld` is 0 and all four window outputs keep their previous values. Idle cycles do not count as pixels for R3 to R5.
- R9: After `IMG_W`*`IMG_H` accepted pixels, the next pixel is at row 0, column 0 of a new frame.
- R10: A pixel accepted with `pix_sof` = 1 is placed at row 0, column 0, whatever the tracker's position. Positions then continue from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_vld | input | 1 | Input pixel qualifier |
| pix_sof | input | 1 | Marks the accepted pixel as row 0, column 0 |
| pix_in | input | PIX_W | Input pixel value |
| win_vld | output | 1 | All four window outputs hold in-frame pixels |
| win_cur | output | PIX_W | Newest accepted pixel |
| win_left | output | PIX_W | Left neighbour of `win_cur` |
| win_up | output | PIX_W | Pixel above `win_cur` |
| win_upleft | output | PIX_W | Pixel above and left of `win_cur` |

## Verification
The bench builds the block with `IMG_W` = 5, `IMG_H` = 4 and `PIX_W` = 8. With a frame of only 20 pixels, a few thousand random cycles cross many row boundaries, column-0 pixels and frame wraps. Each cycle has a 70 % chance of carrying a pixel, so the random traffic also mixes idle gaps and occasional start-of-frame markers into those crossings. The 5-pixel row keeps the `IMG_W` and `IMG_W`+1 taps short enough that a bench history of 6 entries covers them. A directed pass streams two back-to-back frames first, to reach the frame wrap and the column-0 edge without gaps.

// File: rtl/win_pkg.sv
package win_pkg;

  // Counter width that stays legal when the count is 1.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/win_pos_track.sv
module win_pos_track #(
  parameter int unsigned IMG_W = 64,
  parameter int unsigned IMG_H = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic sof,
  output logic win_ok
);
  import win_pkg::*;

  localparam int unsigned COL_W = cnt_w(IMG_W);
  localparam int unsigned ROW_W = cnt_w(IMG_H);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0] col_q, col_d, col_eff;
  logic [ROW_W-1:0] row_q, row_d, row_eff;

  // Position of the pixel on the input this cycle.
  always_comb begin
    col_eff = sof ? '0 : col_q;
    row_eff = sof ? '0 : row_q;
    win_ok  = (col_eff != '0) && (row_eff != '0);
  end

  // Position of the next pixel.
  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (adv) begin
      if (col_eff == COL_LAST) begin
        col_d = '0;
        row_d = (row_eff == ROW_LAST) ? '0 : row_eff + ROW_W'(1);
      end else begin
        col_d = col_eff + COL_W'(1);
        row_d = row_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  p_col_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_LAST);

  p_row_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_LAST);

  p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sof && (IMG_W > 1)) |=> (col_q == COL_W'(1) && row_q == '0));

  p_stall_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(col_q) && $stable(row_q)));

endmodule

// File: rtl/win_delay_line.sv
module win_delay_line #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned IMG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] tap_left,
  output logic [PIX_W-1:0] tap_up,
  output logic [PIX_W-1:0] tap_upleft
);

  localparam int unsigned DEPTH = IMG_W + 1;

  // stage k holds the sample accepted k+1 pixels ago
  logic [PIX_W-1:0] stg_q [DEPTH];
  logic [PIX_W-1:0] stg_d [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb stg_d[k] = din;
    end else begin : g_body
      always_comb stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stg_q[k] <= '0;
      else if (en) stg_q[k] <= stg_d[k];
    end
  end

  assign tap_left   = stg_q[0];
  assign tap_up     = stg_q[IMG_W-1];
  assign tap_upleft = stg_q[IMG_W];

  p_hold_taps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(tap_left) && $stable(tap_up) && $stable(tap_upleft)));

endmodule

// File: rtl/win_out_stage.sv
module win_out_stage #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ok,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] left_i,
  input  logic [PIX_W-1:0] up_i,
  input  logic [PIX_W-1:0] ul_i,
  output logic             vld_o,
  output logic [PIX_W-1:0] cur_o,
  output logic [PIX_W-1:0] left_o,
  output logic [PIX_W-1:0] up_o,
  output logic [PIX_W-1:0] ul_o
);

  logic vld_d;

  always_comb vld_d = load && ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o  <= '0;
      left_o <= '0;
      up_o   <= '0;
      ul_o   <= '0;
    end else if (load) begin
      cur_o  <= cur_i;
      left_o <= left_i;
      up_o   <= up_i;
      ul_o   <= ul_i;
    end
  end

endmodule

// File: rtl/win2x2_raster.sv
module win2x2_raster #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned IMG_W = 64,
  parameter int unsigned IMG_H = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic             pix_sof,
  input  logic [PIX_W-1:0] pix_in,
  output logic             win_vld,
  output logic [PIX_W-1:0] win_cur,
  output logic [PIX_W-1:0] win_left,
  output logic [PIX_W-1:0] win_up,
  output logic [PIX_W-1:0] win_upleft
);

  logic             win_ok;
  logic [PIX_W-1:0] tap_left, tap_up, tap_ul;

  win_pos_track #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (pix_vld),
    .sof    (pix_sof),
    .win_ok (win_ok)
  );

  win_delay_line #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_dline (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (pix_vld),
    .din        (pix_in),
    .tap_left   (tap_left),
    .tap_up     (tap_up),
    .tap_upleft (tap_ul)
  );

  win_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (pix_vld),
    .ok     (win_ok),
    .cur_i  (pix_in),
    .left_i (tap_left),
    .up_i   (tap_up),
    .ul_i   (tap_ul),
    .vld_o  (win_vld),
    .cur_o  (win_cur),
    .left_o (win_left),
    .up_o   (win_up),
    .ul_o   (win_upleft)
  );

  p_cur_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> (win_cur == $past(pix_in)));

  p_left_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && $past(pix_vld)) |=> (win_left == $past(pix_in, 2)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> (!win_vld && $stable(win_cur) && $stable(win_left)));

  p_sof_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && pix_sof) |=> !win_vld);

endmodule

// File: tb/test_win2x2_raster.sv
module test_win2x2_raster;

  localparam int unsigned PW = 8;
  localparam int unsigned W  = 5;
  localparam int unsigned H  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_vld, pix_sof;
  logic [PW-1:0] pix_in;
  logic          win_vld;
  logic [PW-1:0] win_cur, win_left, win_up, win_upleft;

  always #5 clk = ~clk;

  win2x2_raster #(.PIX_W(PW), .IMG_W(W), .IMG_H(H)) i_win2x2_raster (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_sof(pix_sof),
    .pix_in(pix_in), .win_vld(win_vld), .win_cur(win_cur),
    .win_left(win_left), .win_up(win_up), .win_upleft(win_upleft)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // bench model
  logic [PW-1:0] hist [W+1];
  int            m_row, m_col, m_frames;
  logic          e_vld;
  logic [PW-1:0] e_cur, e_left, e_up, e_ul;
  string         e_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string vld_tag(input int r, input int c, input bit sof, input int fr);
    if (sof)             return "R10";
    if (r == 0 && fr > 0) return "R9";
    if (r == 0)          return "R6";
    if (c == 0)          return "R7";
    return "R2";
  endfunction

  // Called before the edge on which the inputs are sampled.
  task automatic model_step(input bit v, input bit s, input logic [PW-1:0] p);
    int r, c;
    if (!v) begin
      e_vld = 1'b0;
      e_tag = "R8";
      return;
    end
    r = s ? 0 : m_row;
    c = s ? 0 : m_col;
    e_vld  = (r >= 1) && (c >= 1);
    e_tag  = vld_tag(r, c, s, m_frames);
    e_cur  = p;
    e_left = hist[0];
    e_up   = hist[W-1];
    e_ul   = hist[W];
    for (int k = W; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = p;
    if (c == W-1) begin
      m_col = 0;
      if (r == H-1) begin m_row = 0; m_frames++; end
      else m_row = r + 1;
    end else begin
      m_col = c + 1;
      m_row = r;
    end
  endtask

  task automatic check_outputs();
    chk({e_tag, " vld"}, 32'(win_vld), 32'(e_vld));
    chk((e_tag == "R8") ? "R8 cur hold" : "R2 cur", 32'(win_cur), 32'(e_cur));
    if (e_tag == "R8") begin
      chk("R8 left hold", 32'(win_left), 32'(e_left));
    end
    if (e_vld) begin
      chk("R3 left", 32'(win_left), 32'(e_left));
      chk("R4 up", 32'(win_up), 32'(e_up));
      chk("R5 upleft", 32'(win_upleft), 32'(e_ul));
    end
  endtask

  task automatic cycle(input bit v, input bit s, input logic [PW-1:0] p);
    @(negedge clk);
    check_outputs();
    pix_vld = v; pix_sof = s; pix_in = p;
    model_step(v, s, p);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_2b2b);
    rst_n = 1'b0; pix_vld = 1'b0; pix_sof = 1'b0; pix_in = '0;
    for (int k = 0; k <= W; k++) hist[k] = '0;
    m_row = 0; m_col = 0; m_frames = 0;
    e_vld = 1'b0; e_cur = '0; e_left = '0; e_up = '0; e_ul = '0; e_tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", 32'(win_vld), 32'd0);
    chk("R1 cur in reset", 32'(win_cur), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld", 32'(win_vld), 32'd0);
    chk("R1 cur", 32'(win_cur), 32'd0);
    chk("R1 left", 32'(win_left), 32'd0);
    chk("R1 up", 32'(win_up), 32'd0);
    chk("R1 upleft", 32'(win_upleft), 32'd0);

    // Directed: two back-to-back frames, sof on the first pixel.
    for (int i = 0; i < 2*W*H; i++) cycle(1'b1, (i == 0), PW'(i + 1));
    // Directed: idle gap in the middle of a row.
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 8'hEE);
    for (int i = 0; i < W + 2; i++) cycle(1'b1, 1'b0, PW'(8'h80 + i));
    // Directed: sof in the middle of a frame.
    cycle(1'b1, 1'b1, 8'h55);
    for (int i = 0; i < 2*W + 1; i++) cycle(1'b1, 1'b0, PW'(8'hA0 + i));

    // Random traffic.
    for (int i = 0; i < 4000; i++) begin
      bit v, s;
      v = ($urandom % 10) < 7;
      s = ($urandom % 50) == 0;
      cycle(v, s, PW'($urandom));
    end
    cycle(1'b0, 1'b0, '0);
    @(negedge clk);
    check_outputs();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule